// File: doc/BRIEF.md
# Single-Level Fixed-Priority Interrupt Controller

This block collects four interrupt sources for a small processor core and presents at most one of them at a time as a registered request with a vector address. Two sources are active-low external pins, each of which can be captured on a falling edge or followed as a level. The third source is the overflow flag of a timer/counter that lives elsewhere. The fourth source is a time-base timer inside this block. That timer counts machine cycles (one for every twelve clocks) into a 10-bit counter. Each time the counter wraps, it raises a sticky flag.

An enable byte holds one global gate and one gate for each source. When several gated sources are pending together, they are resolved in one fixed order. The core takes the presented vector with a one-cycle acknowledge strobe. From then until a return strobe arrives, the controller issues nothing more, because nesting is not supported. An acknowledge clears the captured edge of the source it takes. The time-base flag is cleared only by its own clear strobe. The counter/timer flag is cleared by its owner.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0 and `tick_flag` is 0.
- R2: When gated requests coincide, the winner is pin 0 first, then the counter/timer flag, then pin 1, then the time-base flag.
- R3: The vector for pin 0 is 0x03, for the counter/timer 0x0B, for pin 1 0x13 and for the time base 0x1B. `irq_vec` is 0x00 whenever `irq_req` is 0.
- R4: `irq_en` bit 7 is the global gate: when it is 0, no request is raised. Bit 0 gates pin 0, bit 1 the counter/timer, bit 2 pin 1 and bit 3 the time base. Bits 6 to 4 have no effect.
- R5: With `pin_edge[i]`=1, a high-to-low change on `pin_n[i]` sets a pending flag, and the request appears two clocks after the falling sample. The flag stays set after the pin returns high. It is cleared when that source's vector is acknowledged. A new edge in the acknowledge cycle wins.
- R6: With `pin_edge[i]`=0, the request follows `pin_n[i]` being low, with no memory of earlier lows.
- R7: While `tick_run` is 1, the time base advances once every 12 clocks. `tick_flag` rises 12*1024 clocks after the first clock that samples `tick_run` high. `tick_run`=0 stops the count and clears it.
- R8: `tick_flag` is cleared only by a `tick_clr` pulse. An acknowledge of its vector leaves it set. A wrap in the same cycle as a clear wins.
- R9: `ack` while `irq_req` is 1 starts service. During service no request is raised until `reti` has been sampled. `ack` while `irq_req` is 0 is ignored.
- R10: `irq_req` and `irq_vec` are registered: a level source seen on one clock edge shows at the outputs after that same edge.
- R11: The counter/timer source is the level of `ctr_ovf`. This block never clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 8 | Enable byte: bit 7 global, bits 3..0 per source |
| pin_edge | input | 2 | 1 = edge capture, 0 = level, per external pin |
| pin_n | input | 2 | External interrupt pins, active low |
| ctr_ovf | input | 1 | Counter/timer overflow flag |
| tick_run | input | 1 | Time-base run; 0 stops and clears it |
| tick_clr | input | 1 | Pulse that clears the time-base flag |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Core leaves the service routine |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 8 | Registered vector address |
| tick_flag | output | 1 | Time-base wrap flag |

## Verification
The stimulus covers several distinct cases:
- All four sources asserted together and then served one by one. This shows whether the fixed order and the vector mapping are correct.
- Single sources under different enable bytes, with the global gate low and with only the reserved bits set. This separates the gating from the priority logic.
- A one-cycle pulse on a pin in edge mode, compared with a held low in level mode. This tells memory apart from following the pin.
- A full time-base wrap, timed to the exact clock.
- An acknowledge of the time-base vector, a stray acknowledge with nothing pending, and a run drop partway through a count. These show what clears which state.

A behavioural reference model is compared with the outputs on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_SRC = 4;
    localparam int SRC_W = 2;
    typedef logic [SRC_W-1:0] src_t;
    // Index order is also the priority order (lower index wins)
    localparam src_t SRC_PIN0 = 2'd0;
    localparam src_t SRC_CTR  = 2'd1;
    localparam src_t SRC_PIN1 = 2'd2;
    localparam src_t SRC_TICK = 2'd3;
    localparam int GATE_BIT   = 7;
endpackage

// File: rtl/irq_pin_latch.sv
module irq_pin_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    typedef struct packed {
        logic prev;
        logic flag;
    } pin_st_t;

    pin_st_t st_q, st_d;
    logic    fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.prev && !pin_n;
        st_d.prev = pin_n;
        if (!edge_mode)
            st_d.flag = 1'b0;
        else if (fall)
            st_d.flag = 1'b1;
        else if (clr)
            st_d.flag = 1'b0;
        req = edge_mode ? st_q.flag : !pin_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end

    // R5: a falling sample in edge mode leaves a pending flag
    assert_edge_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && st_q.prev && !pin_n) |=> st_q.flag);
endmodule

// File: rtl/irq_timebase.sv
module irq_timebase #(
    parameter int PRESC = 12,
    parameter int TB_W  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic flag_clr,
    output logic flag
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

    typedef struct packed {
        logic [PW-1:0]   presc;
        logic [TB_W-1:0] cnt;
        logic            flag;
    } tb_st_t;

    tb_st_t st_q, st_d;
    logic   tick, carry;

    always_comb begin
        st_d  = st_q;
        tick  = run && (st_q.presc == PW'(PRESC - 1));
        carry = tick && (&st_q.cnt);
        if (!run) begin
            st_d.presc = '0;
            st_d.cnt   = '0;
        end else if (tick) begin
            st_d.presc = '0;
            st_d.cnt   = st_q.cnt + 1'b1;
        end else begin
            st_d.presc = st_q.presc + 1'b1;
        end
        if (carry)
            st_d.flag = 1'b1;
        else if (flag_clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R7: a stopped time base holds a cleared count
    assert_run_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0 && st_q.presc == '0));
    // R8: only the clear strobe removes the flag
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !flag_clr) |=> st_q.flag);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     raw,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = |raw;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (raw[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8,
    parameter int PRESC    = 12,
    parameter int TB_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       irq_en,
    input  logic [1:0]       pin_edge,
    input  logic [1:0]       pin_n,
    input  logic             ctr_ovf,
    input  logic             tick_run,
    input  logic             tick_clr,
    input  logic             ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             tick_flag
);
    typedef struct packed {
        logic             busy;
        logic             req;
        src_t             src;
        logic [VEC_W-1:0] vec;
    } arb_st_t;

    arb_st_t          q, d;
    logic             take;
    logic [1:0]       pin_req;
    logic [1:0]       pin_clr;
    logic [N_SRC-1:0] src_vec, raw;
    logic             hit;
    src_t             pick_idx;

    assign take = ack && q.req;

    for (genvar g = 0; g < 2; g++) begin : g_pin
        localparam src_t MY_SRC = (g == 0) ? SRC_PIN0 : SRC_PIN1;
        assign pin_clr[g] = take && (q.src == MY_SRC);
        irq_pin_latch u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (pin_n[g]),
            .edge_mode (pin_edge[g]),
            .clr       (pin_clr[g]),
            .req       (pin_req[g])
        );
    end

    irq_timebase #(.PRESC(PRESC), .TB_W(TB_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tick_run),
        .flag_clr (tick_clr),
        .flag     (tick_flag)
    );

    always_comb begin
        src_vec           = '0;
        src_vec[SRC_PIN0] = pin_req[0];
        src_vec[SRC_CTR]  = ctr_ovf;
        src_vec[SRC_PIN1] = pin_req[1];
        src_vec[SRC_TICK] = tick_flag;
        raw = src_vec & irq_en[N_SRC-1:0] & {N_SRC{irq_en[GATE_BIT]}};
    end

    irq_prio_pick #(.N(N_SRC), .IDX_W(SRC_W)) u_pick (
        .raw (raw),
        .hit (hit),
        .idx (pick_idx)
    );

    always_comb begin
        d = q;
        if (reti)
            d.busy = 1'b0;
        else if (take)
            d.busy = 1'b1;
        d.req = hit && !q.busy && !take;
        d.src = pick_idx;
        d.vec = d.req ? VEC_W'(VEC_BASE + VEC_STEP * int'(pick_idx)) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_req = q.req;
    assign irq_vec = q.vec;

    // R9: an accepted vector starts service and silences the request
    assert_ack_starts_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> (q.busy && !irq_req));
    // R9: nothing is requested while a routine is in service
    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !irq_req);
    // R4: a request needs the global gate on the previous edge
    assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(irq_en[GATE_BIT]));
    // R3: no vector is shown without a request
    assert_idle_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0));
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WRAP = 12 * 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_en = 8'h00;
    logic [1:0] pin_edge = 2'b00;
    logic [1:0] pin_n = 2'b11;
    logic       ctr_ovf = 1'b0, tick_run = 1'b0, tick_clr = 1'b0;
    logic       ack = 1'b0, reti = 1'b0;
    logic       irq_req, tick_flag;
    logic [7:0] irq_vec;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .pin_edge(pin_edge),
        .pin_n(pin_n), .ctr_ovf(ctr_ovf), .tick_run(tick_run),
        .tick_clr(tick_clr), .ack(ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .tick_flag(tick_flag)
    );

    // Behavioural reference model
    int m_prev0, m_prev1, m_f0, m_f1, m_presc, m_cnt, m_tf;
    int m_busy, m_req, m_vec, m_src;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev0 = 1; m_prev1 = 1; m_f0 = 0; m_f1 = 0;
            m_presc = 0; m_cnt = 0; m_tf = 0;
            m_busy = 0; m_req = 0; m_vec = 0; m_src = 0;
        end else begin
            int s[4];
            int take, win, n_f0, n_f1, carry;
            take = (ack && m_req) ? 1 : 0;
            s[0] = pin_edge[0] ? m_f0 : (pin_n[0] ? 0 : 1);
            s[1] = ctr_ovf ? 1 : 0;
            s[2] = pin_edge[1] ? m_f1 : (pin_n[1] ? 0 : 1);
            s[3] = m_tf;
            win = -1;
            for (int i = 3; i >= 0; i--)
                if (s[i] != 0 && irq_en[i] && irq_en[7]) win = i;
            n_f0 = !pin_edge[0] ? 0 : (m_prev0 && !pin_n[0]) ? 1 :
                   (take && m_src == 0) ? 0 : m_f0;
            n_f1 = !pin_edge[1] ? 0 : (m_prev1 && !pin_n[1]) ? 1 :
                   (take && m_src == 2) ? 0 : m_f1;
            carry = 0;
            if (!tick_run) begin
                m_presc = 0; m_cnt = 0;
            end else if (m_presc == 11) begin
                m_presc = 0;
                if (m_cnt == 1023) begin m_cnt = 0; carry = 1; end
                else m_cnt = m_cnt + 1;
            end else m_presc = m_presc + 1;
            if (carry) m_tf = 1; else if (tick_clr) m_tf = 0;
            m_req = (win >= 0 && !m_busy && !take) ? 1 : 0;
            m_vec = m_req ? 3 + 8 * win : 0;
            m_src = (win >= 0) ? win : 0;
            if (reti) m_busy = 0; else if (take) m_busy = 1;
            m_f0 = n_f0; m_f1 = n_f1;
            m_prev0 = pin_n[0]; m_prev1 = pin_n[1];
        end
    end

    // R10: per-clock comparison of the registered outputs with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_req !== m_req[0] || irq_vec !== 8'(m_vec) || tick_flag !== m_tf[0]) begin
                fails++;
                $display("FAIL R10 model: req=%0b vec=%02h tf=%0b expected req=%0b vec=%02h tf=%0b",
                         irq_req, irq_vec, tick_flag, m_req[0], 8'(m_vec), m_tf[0]);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic r, input logic [7:0] v, input string tag);
        checks++;
        if (irq_req !== r || irq_vec !== v) begin
            fails++;
            $display("FAIL %s: req=%0b vec=%02h expected req=%0b vec=%02h", tag, irq_req, irq_vec, r, v);
        end
    endtask

    task automatic expect_tf(input logic t, input string tag);
        checks++;
        if (tick_flag !== t) begin
            fails++;
            $display("FAIL %s: tick_flag=%0b expected %0b", tag, tick_flag, t);
        end
    endtask

    task automatic pulse_ack;
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic pulse_reti;
        reti = 1'b1; step(1); reti = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        step(2);
        expect_out(1'b0, 8'h00, "R1 reset outputs");
        expect_tf(1'b0, "R1 reset flag");
        rst_n = 1'b1;
        step(2);
        expect_out(1'b0, 8'h00, "R1 after release");

        // R7: exact wrap time, with the source gated off
        tick_run = 1'b1;
        step(WRAP - 1);
        expect_tf(1'b0, "R7 one clock before wrap");
        step(1);
        expect_tf(1'b1, "R7 wrap flag");
        expect_out(1'b0, 8'h00, "R4 time base not enabled");

        // R2/R3: all four pending together
        irq_en = 8'h8F; ctr_ovf = 1'b1; pin_n = 2'b00;
        step(1);
        expect_out(1'b1, 8'h03, "R2 pin 0 wins");
        pulse_ack();
        expect_out(1'b0, 8'h00, "R9 quiet after ack");
        pin_n[0] = 1'b1;
        step(3);
        expect_out(1'b0, 8'h00, "R9 still in service");
        pulse_reti();
        expect_out(1'b0, 8'h00, "R9 reti edge");
        step(1);
        expect_out(1'b1, 8'h0B, "R2 counter next");
        pulse_ack(); ctr_ovf = 1'b0; pulse_reti(); step(1);
        expect_out(1'b1, 8'h13, "R2 pin 1 next");
        pulse_ack(); pin_n[1] = 1'b1; pulse_reti(); step(1);
        expect_out(1'b1, 8'h1B, "R3 time base vector");
        pulse_ack(); pulse_reti(); step(1);
        expect_tf(1'b1, "R8 ack leaves flag");
        expect_out(1'b1, 8'h1B, "R8 time base again");
        tick_clr = 1'b1; step(1); tick_clr = 1'b0;
        expect_tf(1'b0, "R8 clear strobe");
        step(1);
        pulse_ack(); pulse_reti(); step(2);
        expect_out(1'b0, 8'h00, "R8 nothing left");

        // R7: a drop of run clears a partial count
        step(WRAP / 2);
        tick_run = 1'b0; step(1); tick_run = 1'b1;
        step(WRAP - 1);
        expect_tf(1'b0, "R7 restart from zero");
        step(1);
        expect_tf(1'b1, "R7 wrap after restart");
        tick_run = 1'b0; tick_clr = 1'b1; step(1); tick_clr = 1'b0;
        step(1);
        expect_out(1'b0, 8'h00, "R8 cleared before service");

        // R4/R11: gating of the counter flag
        ctr_ovf = 1'b1; irq_en = 8'h02; step(2);
        expect_out(1'b0, 8'h00, "R4 global gate off");
        irq_en = 8'hF0; step(2);
        expect_out(1'b0, 8'h00, "R4 reserved bits only");
        irq_en = 8'h82; step(1);
        expect_out(1'b1, 8'h0B, "R11 counter level");
        ctr_ovf = 1'b0; step(1);
        expect_out(1'b0, 8'h00, "R11 request follows flag");

        // R9: stray ack is ignored
        pulse_ack(); step(1);
        ctr_ovf = 1'b1; step(1);
        expect_out(1'b1, 8'h0B, "R9 stray ack ignored");
        ctr_ovf = 1'b0; step(2);

        // R6: level mode has no memory
        irq_en = 8'h81; pin_edge = 2'b00;
        pin_n[0] = 1'b0; step(1);
        expect_out(1'b1, 8'h03, "R6 level low");
        pin_n[0] = 1'b1; step(1);
        expect_out(1'b0, 8'h00, "R6 level released");

        // R5: edge capture on pin 1
        irq_en = 8'h84; pin_edge = 2'b10;
        step(1);
        pin_n[1] = 1'b0; step(1);
        expect_out(1'b0, 8'h00, "R5 one clock after fall");
        pin_n[1] = 1'b1; step(1);
        expect_out(1'b1, 8'h13, "R5 edge request");
        step(3);
        expect_out(1'b1, 8'h13, "R5 edge remembered");
        pulse_ack(); pulse_reti(); step(2);
        expect_out(1'b0, 8'h00, "R5 ack clears edge");

        step(3);
        finish_run();
    end
endmodule